// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides which pending interrupt level, if any, is offered to the processor. Three level-wide vectors feed it: the pending requests, the mask and the in-service set. A level-pointer names the level that currently has the lowest priority, and a flag selects special-mask operation. When an evaluation strobe is given, the block makes its decision and registers it. The result is one interrupt output and the number of the level that was chosen.

Priority rotates. The level directly above the pointer, counted modulo the number of levels, has the highest priority. The search then moves upward and wraps around. In normal operation a level can win only if it comes ahead of the first in-service level in that search order. In special-mask operation every level whose in-service bit is clear may win.

A new level is granted only while the output is low. While the output is high it stays high until no unmasked request remains. Acknowledge handling and register programming are done by neighbouring logic. That logic pulses the strobe each time one of the input vectors changes.

Top module: `irq_priority_resolver`

## Requirements
- R1: During and after reset, and before the first strobe, `irq_o` is 0 and `level_o` is 0.
- R2: While `eval_strobe_i` is low, `irq_o` and `level_o` do not change, whatever the other inputs do.
- R3: An evaluation takes effect on the rising clock edge at which `eval_strobe_i` is sampled high. The new outputs are visible right after that edge.
- R4: The highest-priority level is (`low_ptr_i` + 1) mod 8. The search goes upward from there with wraparound, and the first candidate found is the one granted. Level k is bit k of every vector.
- R5: Only bits set in `req_i` and clear in `mask_i` can be candidates. A masked request is never granted.
- R6: With `special_mask_i` = 0, only levels ahead of the first set `insvc_i` bit in search order are candidates. If the highest-priority level itself is in service, the evaluation changes nothing at all, and that includes a deassertion.
- R7: With `special_mask_i` = 1, every level whose `insvc_i` bit is clear is a candidate. The order of the in-service bits plays no part.
- R8: If `irq_o` is 1 and an unmasked request exists, the evaluation leaves `irq_o` at 1 and `level_o` unchanged.
- R9: If `irq_o` is 1, no unmasked request exists and the case is not blocked as in R6, the evaluation clears `irq_o` and keeps `level_o`.
- R10: If `irq_o` is 0 and there is no candidate, the evaluation leaves `irq_o` at 0 and `level_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_strobe_i | input | 1 | Start one evaluation at this edge |
| req_i | input | 8 | Pending request per level |
| mask_i | input | 8 | Mask per level, 1 blocks the level |
| insvc_i | input | 8 | In-service flag per level |
| low_ptr_i | input | 3 | Level with the lowest priority |
| special_mask_i | input | 1 | 1 selects special-mask operation |
| irq_o | output | 1 | Interrupt request to the processor |
| level_o | output | 3 | Level latched at the last grant |

## Verification
A faulty rotation or a faulty in-service cutoff shows up on `level_o` right after the strobe edge. Depending on the fault, the wrong neighbour wins, or a request that should be refused is granted. Mishandling of the held output state does not show as a wrong level. It shows as a deassertion that is missing or that comes too early, and this is visible on `irq_o` one cycle after the strobe. A silent change with no strobe appears as an output that moves on an idle cycle.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int unsigned PRIO_LEVELS_DEFAULT = 8;

    typedef enum logic [1:0] {
        DEC_KEEP  = 2'd0,
        DEC_GRANT = 2'd1,
        DEC_DROP  = 2'd2
    } prio_decision_e;

endpackage

// File: rtl/prio_rotate.sv
module prio_rotate #(
    parameter int unsigned N  = 8,
    parameter int unsigned LW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    input  logic [LW-1:0] shift_i,
    output logic [N-1:0]  vec_o
);
    // Output position i holds the level that lies i steps after shift_i.
    for (genvar i = 0; i < N; i++) begin : g_lane
        logic [LW-1:0] src;
        assign src      = LW'(i) + shift_i;
        assign vec_o[i] = vec_i[src];
    end
endmodule

// File: rtl/prio_first_set.sv
module prio_first_set #(
    parameter int unsigned N  = 8,
    parameter int unsigned LW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [LW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = LW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_priority_resolver.sv
module irq_priority_resolver
    import irq_prio_pkg::*;
#(
    parameter int unsigned N = PRIO_LEVELS_DEFAULT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 eval_strobe_i,
    input  logic [N-1:0]         req_i,
    input  logic [N-1:0]         mask_i,
    input  logic [N-1:0]         insvc_i,
    input  logic [$clog2(N)-1:0] low_ptr_i,
    input  logic                 special_mask_i,
    output logic                 irq_o,
    output logic [$clog2(N)-1:0] level_o
);
    // N must be a power of two so that level arithmetic wraps by truncation.
    localparam int unsigned LW = $clog2(N);

    typedef struct packed {
        logic          irq;
        logic [LW-1:0] level;
    } resolver_state_t;

    resolver_state_t state_d, state_q;

    logic [LW-1:0]  top_lvl;
    logic [N-1:0]   unmasked;
    logic [N-1:0]   isr_rot;
    logic [N-1:0]   req_rot;
    logic [N-1:0]   allowed_rot;
    logic [N-1:0]   cand_rot;
    logic           isr_any;
    logic [LW-1:0]  isr_first;
    logic           cand_any;
    logic [LW-1:0]  cand_idx;
    logic           blocked;
    prio_decision_e decision;

    assign top_lvl  = low_ptr_i + LW'(1);
    assign unmasked = req_i & ~mask_i;

    prio_rotate #(.N(N), .LW(LW)) u_rot_isr (
        .vec_i   (insvc_i),
        .shift_i (top_lvl),
        .vec_o   (isr_rot)
    );

    prio_rotate #(.N(N), .LW(LW)) u_rot_req (
        .vec_i   (unmasked),
        .shift_i (top_lvl),
        .vec_o   (req_rot)
    );

    prio_first_set #(.N(N), .LW(LW)) u_first_isr (
        .vec_i   (isr_rot),
        .found_o (isr_any),
        .idx_o   (isr_first)
    );

    // In normal mode only the positions ahead of the first in-service one
    // may win. In special-mask mode the in-service positions are dropped one by one.
    always_comb begin
        allowed_rot = '1;
        if (special_mask_i) begin
            allowed_rot = ~isr_rot;
        end else if (isr_any) begin
            for (int j = 0; j < N; j++) begin
                allowed_rot[j] = (LW'(j) < isr_first);
            end
        end
    end

    assign blocked  = !special_mask_i && isr_any && (isr_first == '0);
    assign cand_rot = req_rot & allowed_rot;

    prio_first_set #(.N(N), .LW(LW)) u_first_cand (
        .vec_i   (cand_rot),
        .found_o (cand_any),
        .idx_o   (cand_idx)
    );

    always_comb begin
        decision = DEC_KEEP;
        if (eval_strobe_i && !blocked) begin
            if (!state_q.irq && cand_any) begin
                decision = DEC_GRANT;
            end else if (state_q.irq && (unmasked == '0)) begin
                decision = DEC_DROP;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (decision)
            DEC_GRANT: begin
                state_d.irq   = 1'b1;
                state_d.level = cand_idx + top_lvl;
            end
            DEC_DROP: state_d.irq = 1'b0;
            default:  state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_o   = state_q.irq;
    assign level_o = state_q.level;

    // R2: idle cycles leave the outputs untouched
    a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_strobe_i |=> ($stable(irq_o) && $stable(level_o)));

    // R3: a rise of the output always follows a sampled strobe
    a_r3_rise_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(eval_strobe_i));

    // R5: the granted level was an unmasked request
    a_r5_grant_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ((($past(req_i) & ~$past(mask_i)) >> level_o) & N'(1)) != '0);

    // R7: special-mask mode never grants a level that is in service
    a_r7_special_skips_isr: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_o) && $past(special_mask_i)) |-> (($past(insvc_i) >> level_o) & N'(1)) == '0);

    // R8: a high output holds while unmasked requests remain
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && eval_strobe_i && ((req_i & ~mask_i) != '0)) |=> (irq_o && $stable(level_o)));

    // R9: deassertion keeps the latched level
    a_r9_drop_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $stable(level_o));

endmodule

// File: tb/tb_irq_priority_resolver.sv
`timescale 1ns/1ps
module tb_irq_priority_resolver;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       eval_strobe_i = 1'b0;
    logic [7:0] req_i = '0;
    logic [7:0] mask_i = '0;
    logic [7:0] insvc_i = '0;
    logic [2:0] low_ptr_i = 3'd7;
    logic       special_mask_i = 1'b0;
    logic       irq_o;
    logic [2:0] level_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_priority_resolver dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .eval_strobe_i  (eval_strobe_i),
        .req_i          (req_i),
        .mask_i         (mask_i),
        .insvc_i        (insvc_i),
        .low_ptr_i      (low_ptr_i),
        .special_mask_i (special_mask_i),
        .irq_o          (irq_o),
        .level_o        (level_o)
    );

    typedef struct packed {
        logic [7:0] req;
        logic [7:0] mask;
        logic [7:0] isr;
        logic [2:0] ptr;
        logic       sm;
        logic       exp_irq;
        logic [2:0] exp_lvl;
        logic       chk_lvl;
        logic [3:0] tag;
    } vec_t;

    // Each entry starts from a cleared output (irq low).
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{8'h01, 8'h00, 8'h00, 3'd7, 1'b0, 1'b1, 3'd0, 1'b1, 4'd4},  // R4 top level 0
        '{8'h81, 8'h00, 8'h00, 3'd7, 1'b0, 1'b1, 3'd0, 1'b1, 4'd4},  // R4 0 beats 7
        '{8'h81, 8'h00, 8'h00, 3'd0, 1'b0, 1'b1, 3'd7, 1'b1, 4'd4},  // R4 rotated: 7 beats 0
        '{8'h06, 8'h00, 8'h00, 3'd1, 1'b0, 1'b1, 3'd2, 1'b1, 4'd4},  // R4
        '{8'h06, 8'h00, 8'h00, 3'd2, 1'b0, 1'b1, 3'd1, 1'b1, 4'd4},  // R4 wraparound
        '{8'h0C, 8'h04, 8'h00, 3'd7, 1'b0, 1'b1, 3'd3, 1'b1, 4'd5},  // R5 masked skipped
        '{8'h04, 8'h04, 8'h00, 3'd7, 1'b0, 1'b0, 3'd0, 1'b0, 4'd5},  // R5 only masked
        '{8'h30, 8'h00, 8'h10, 3'd7, 1'b0, 1'b0, 3'd0, 1'b0, 4'd6},  // R6 behind isr
        '{8'h0A, 8'h00, 8'h10, 3'd7, 1'b0, 1'b1, 3'd1, 1'b1, 4'd6},  // R6 ahead of isr
        '{8'hFF, 8'h00, 8'h01, 3'd7, 1'b0, 1'b0, 3'd0, 1'b0, 4'd6},  // R6 top in service
        '{8'h03, 8'h00, 8'h01, 3'd3, 1'b0, 1'b0, 3'd0, 1'b0, 4'd6},  // R6 rotated cutoff
        '{8'hC3, 8'h00, 8'h01, 3'd3, 1'b0, 1'b1, 3'd6, 1'b1, 4'd6},  // R6 rotated grant
        '{8'h30, 8'h00, 8'h10, 3'd7, 1'b1, 1'b1, 3'd5, 1'b1, 4'd7},  // R7 skip isr level
        '{8'h10, 8'h00, 8'h10, 3'd7, 1'b1, 1'b0, 3'd0, 1'b0, 4'd7},  // R7 only isr level
        '{8'h03, 8'h00, 8'h01, 3'd7, 1'b1, 1'b1, 3'd1, 1'b1, 4'd7}   // R7 top in service
    };

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Drive at a falling edge, strobe for one rising edge, return at the next falling edge.
    task automatic evaluate(input logic [7:0] rq, input logic [7:0] mk, input logic [7:0] is,
                            input logic [2:0] pt, input logic sm);
        @(negedge clk);
        req_i = rq; mask_i = mk; insvc_i = is; low_ptr_i = pt; special_mask_i = sm;
        eval_strobe_i = 1'b1;
        @(negedge clk);
        eval_strobe_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R1", "irq in reset", int'(irq_o), 0);
        check("R1", "level in reset", int'(level_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "irq after reset", int'(irq_o), 0);

        for (int k = 0; k < NV; k++) begin
            evaluate(8'h00, 8'h00, 8'h00, 3'd7, 1'b0);
            check("R9", "clear before vector", int'(irq_o), 0);
            evaluate(VECS[k].req, VECS[k].mask, VECS[k].isr, VECS[k].ptr, VECS[k].sm);
            check($sformatf("R%0d", VECS[k].tag), $sformatf("vector %0d irq", k),
                  int'(irq_o), int'(VECS[k].exp_irq));
            if (VECS[k].chk_lvl)
                check($sformatf("R%0d", VECS[k].tag), $sformatf("vector %0d level", k),
                      int'(level_o), int'(VECS[k].exp_lvl));
        end

        // R3: visible right after the strobe edge, not before
        evaluate(8'h00, 8'h00, 8'h00, 3'd7, 1'b0);
        @(negedge clk);
        req_i = 8'h04; low_ptr_i = 3'd1; eval_strobe_i = 1'b1;
        #1;
        check("R3", "irq before edge", int'(irq_o), 0);
        @(posedge clk); #1;
        eval_strobe_i = 1'b0;
        check("R3", "irq right after edge", int'(irq_o), 1);
        check("R3", "level right after edge", int'(level_o), 2);

        // R2: inputs move without a strobe
        @(negedge clk);
        req_i = 8'h00; mask_i = 8'hFF; insvc_i = 8'h00; low_ptr_i = 3'd5;
        repeat (3) @(negedge clk);
        check("R2", "irq without strobe", int'(irq_o), 1);
        check("R2", "level without strobe", int'(level_o), 2);

        // R8: higher-priority unmasked request while high
        evaluate(8'h01, 8'h00, 8'h00, 3'd7, 1'b0);
        check("R8", "irq held", int'(irq_o), 1);
        check("R8", "level held", int'(level_o), 2);

        // R9: all requests masked, output drops, level kept
        evaluate(8'h01, 8'h01, 8'h00, 3'd7, 1'b0);
        check("R9", "irq dropped", int'(irq_o), 0);
        check("R9", "level kept", int'(level_o), 2);

        // R6: blocked evaluation does not even deassert
        evaluate(8'h02, 8'h00, 8'h00, 3'd7, 1'b0);
        check("R4", "grant level 1", int'(level_o), 1);
        evaluate(8'h00, 8'h00, 8'h01, 3'd7, 1'b0);
        check("R6", "blocked keeps irq", int'(irq_o), 1);
        evaluate(8'h00, 8'h00, 8'h01, 3'd7, 1'b1);
        check("R9", "special mode drops", int'(irq_o), 0);
        check("R9", "level after drop", int'(level_o), 1);

        // R10: no candidate while low
        evaluate(8'h30, 8'h00, 8'h10, 3'd7, 1'b0);
        check("R10", "irq stays low", int'(irq_o), 0);
        check("R10", "level unchanged", int'(level_o), 1);

        // R1: reset during operation
        evaluate(8'h80, 8'h00, 8'h00, 3'd7, 1'b0);
        check("R4", "grant level 7", int'(level_o), 7);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "irq after mid reset", int'(irq_o), 0);
        check("R1", "level after mid reset", int'(level_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule